// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through first-level cache and the next memory level and absorbs the processor's word stores. Every store is compared with the blocks already held. If its block address matches an entry that is still open, the word is folded into that entry. If nothing open matches, the store opens a fresh entry. The processor stalls only when every entry is occupied and none of the open ones matches.

Entries leave in the order they were opened. The oldest entry is offered to memory as one block-wide write: the block address, one bit per word that marks the words holding data, and the packed block data. The offered entry is locked. Stores to its block open a new entry, so the offered payload stays constant until memory takes it.

Top module: `wb_merge_buffer`

## Requirements
- R1: When the buffer holds nothing, `st_ready` is high. A store accepted at a clock edge is offered on the memory port from the next cycle: `mw_addr` is the store address with its low log2(WORDS) bits dropped, and the mask bit for word `st_addr[log2(WORDS)-1:0]` is set.
- R2: A store whose block address equals that of an open entry other than the one being offered is merged into that entry. No new entry is used.
- R3: When a merged store hits a word that already holds data, the newer data replaces the older.
- R4: The entry currently offered to memory never takes merges. A store to its block opens a new entry.
- R5: When all ENTRIES entries are occupied and no open entry matches, `st_ready` is low and the store is not written anywhere. When all entries are occupied and an open entry matches, `st_ready` is high.
- R6: Entries are offered to memory in the order they were opened.
- R7: On the memory port, `mw_mask` bit k is set exactly when word k of the block was written. Word k of the data sits in `mw_data[k*DATA_W +: DATA_W]`. The mask is never zero while `mw_valid` is high.
- R8: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr`, `mw_mask` and `mw_data` hold steady.
- R9: An entry freed by a memory handshake can be taken only from the next cycle. A full buffer keeps `st_ready` low during the handshake cycle itself.
- R10: A merge into one entry and a drain of the oldest entry in the same cycle both take effect.
- R11: During and right after reset, `mw_valid` is low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data word |
| mw_valid | output | 1 | Block write offered to memory |
| mw_ready | input | 1 | Memory takes the offered block |
| mw_addr | output | ADDR_W-log2(WORDS) | Block address |
| mw_mask | output | WORDS | One bit per word holding data |
| mw_data | output | WORDS*DATA_W | Packed block data, word 0 lowest |

## Verification
Stores are applied in four patterns. The first is a single store into an empty buffer, which checks the one-cycle path to the memory port. The second is a mixed sequence that alternates between fresh blocks, repeat blocks and the locked head block, with memory stalled, so that merging, word overwrite and head exclusion show up as distinct drained masks and data. The third fills the buffer with distinct blocks and then issues one more store in the same cycle as a drain, which separates a same-cycle reuse of the freed entry from a next-cycle one. The fourth overlaps a merge with a drain, which shows that neither the merge nor the drain is lost.

// File: rtl/wb_pkg.sv
package wb_pkg;
  // What the store port does with the request presented this cycle.
  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_MERGE = 2'd1,
    WB_ALLOC = 2'd2
  } wb_act_e;
endpackage

// File: rtl/wb_order.sv
// Ring pointers: entries open at the tail, leave from the head.
module wb_order #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             empty,
  output logic             full
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop)  head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
    if (push) tail_d = (tail_q == LAST) ? '0 : tail_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!push && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(ENTRIES));
endmodule

// File: rtl/wb_entry.sv
// One buffered block: valid flag, block address, word mask, word data.
module wb_entry #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = 14,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc,
  input  logic                    merge,
  input  logic                    free,
  input  logic [BLK_W-1:0]        wr_blk,
  input  logic [OFF_W-1:0]        wr_word,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    vld,
  output logic [BLK_W-1:0]        blk,
  output logic [WORDS-1:0]        mask,
  output logic [WORDS*DATA_W-1:0] data
);
  logic                          vld_q, vld_d;
  logic [WORDS-1:0]              mask_q, mask_d, word_bit;
  logic [BLK_W-1:0]              blk_q, blk_d;
  logic [WORDS-1:0][DATA_W-1:0]  data_q, data_d;
  logic                          wr_en;

  assign word_bit = WORDS'(1) << wr_word;
  assign wr_en    = alloc | merge;

  always_comb begin
    vld_d  = vld_q;
    mask_d = mask_q;
    blk_d  = blk_q;
    data_d = data_q;
    if (free) begin
      vld_d  = 1'b0;
      mask_d = '0;
    end
    if (alloc) begin
      vld_d           = 1'b1;
      blk_d           = wr_blk;
      mask_d          = word_bit;
      data_d[wr_word] = wr_data;
    end else if (merge) begin
      mask_d          = mask_q | word_bit;
      data_d[wr_word] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      vld_q  <= vld_d;
      mask_q <= mask_d;
    end
  end

  // Payload registers carry no reset; the valid flag qualifies them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      blk_q  <= blk_d;
      data_q <= data_d;
    end
  end

  assign vld  = vld_q;
  assign blk  = blk_q;
  assign mask = mask_q;
  assign data = data_q;
endmodule

// File: rtl/wb_match.sv
// Parallel block compare against every open entry except the head.
module wb_match #(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 14,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][BLK_W-1:0] blk,
  input  logic [IDX_W-1:0]              head,
  input  logic [BLK_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [ENTRIES-1:0] cand;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign cand[g] = vld[g] && (head != IDX_W'(g)) && (blk[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cand[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |cand;
endmodule

// File: rtl/wb_merge_buffer.sv
module wb_merge_buffer
  import wb_pkg::*;
#(
  parameter int   ADDR_W  = 16,
  parameter int   DATA_W  = 32,
  parameter int   WORDS   = 4,
  parameter int   ENTRIES = 4,
  localparam int  OFF_W   = $clog2(WORDS),
  localparam int  BLK_W   = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [DATA_W-1:0]       st_data,
  output logic                    mw_valid,
  input  logic                    mw_ready,
  output logic [BLK_W-1:0]        mw_addr,
  output logic [WORDS-1:0]        mw_mask,
  output logic [WORDS*DATA_W-1:0] mw_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]                   ent_vld;
  logic [ENTRIES-1:0][BLK_W-1:0]        ent_blk;
  logic [ENTRIES-1:0][WORDS-1:0]        ent_mask;
  logic [ENTRIES-1:0][WORDS*DATA_W-1:0] ent_data;

  logic [IDX_W-1:0] head_i, tail_i, hit_idx;
  logic             empty, full, hit, push, pop;
  logic [BLK_W-1:0] st_blk;
  logic [OFF_W-1:0] st_word;
  wb_act_e          act;

  assign st_blk  = st_addr[ADDR_W-1:OFF_W];
  assign st_word = st_addr[OFF_W-1:0];

  wb_match #(.ENTRIES(ENTRIES), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_match (
    .vld(ent_vld), .blk(ent_blk), .head(head_i), .key(st_blk),
    .hit(hit), .hit_idx(hit_idx)
  );

  // Ready looks only at registered occupancy, so a slot freed by this
  // cycle's drain is not offered until the following cycle.
  always_comb begin
    act = WB_IDLE;
    if (st_valid) begin
      if (hit)        act = WB_MERGE;
      else if (!full) act = WB_ALLOC;
    end
  end

  assign st_ready = hit | ~full;
  assign push     = (act == WB_ALLOC);
  assign pop      = mw_valid & mw_ready;

  wb_order #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_order (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head_i), .tail(tail_i), .empty(empty), .full(full)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    wb_entry #(.DATA_W(DATA_W), .WORDS(WORDS), .BLK_W(BLK_W), .OFF_W(OFF_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (push && (tail_i == IDX_W'(g))),
      .merge   ((act == WB_MERGE) && (hit_idx == IDX_W'(g))),
      .free    (pop && (head_i == IDX_W'(g))),
      .wr_blk  (st_blk),
      .wr_word (st_word),
      .wr_data (st_data),
      .vld     (ent_vld[g]),
      .blk     (ent_blk[g]),
      .mask    (ent_mask[g]),
      .data    (ent_data[g])
    );
  end

  assign mw_valid = ~empty;
  assign mw_addr  = ent_blk[head_i];
  assign mw_mask  = ent_mask[head_i];
  assign mw_data  = ent_data[head_i];
endmodule

// File: rtl/wb_merge_checker.sv
module wb_merge_checker #(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 32,
  parameter int  WORDS  = 4,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BLK_W  = ADDR_W - OFF_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_valid,
  input logic                    st_ready,
  input logic [ADDR_W-1:0]       st_addr,
  input logic                    mw_valid,
  input logic                    mw_ready,
  input logic [BLK_W-1:0]        mw_addr,
  input logic [WORDS-1:0]        mw_mask,
  input logic [WORDS*DATA_W-1:0] mw_data
);
  assert_ready_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mw_valid |-> st_ready);

  assert_first_store_offered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mw_valid && st_valid) |=> (mw_valid
      && mw_addr == $past(st_addr[ADDR_W-1:OFF_W])
      && mw_mask == (WORDS'(1) << $past(st_addr[OFF_W-1:0]))));

  assert_stall_only_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> mw_valid);

  assert_mask_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (mw_mask != '0));

  assert_offer_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)
      && $stable(mw_mask) && $stable(mw_data)));
endmodule

bind wb_merge_buffer wb_merge_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
) u_wb_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_addr(st_addr), .mw_valid(mw_valid), .mw_ready(mw_ready),
  .mw_addr(mw_addr), .mw_mask(mw_mask), .mw_data(mw_data)
);

// File: tb/tb_wb_merge_buffer.sv
module tb_wb_merge_buffer;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int BLK_W  = 14;
  localparam int BD_W   = WORDS * DATA_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              st_valid = 1'b0;
  logic              st_ready;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic              mw_valid;
  logic              mw_ready = 1'b0;
  logic [BLK_W-1:0]  mw_addr;
  logic [WORDS-1:0]  mw_mask;
  logic [BD_W-1:0]   mw_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  wb_merge_buffer dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_mask(mw_mask), .mw_data(mw_data)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              rdy;
  } stim_t;

  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic [WORDS-1:0] mask;
    logic [BD_W-1:0]  data;
  } drain_t;

  // Stores applied with memory stalled; rdy is the expected st_ready.
  localparam stim_t STIM [10] = '{
    '{16'h0010, 32'h1111_0000, 1'b1},  // empty: opens head entry (R1)
    '{16'h0011, 32'h2222_0001, 1'b1},  // matches head only: new entry (R4)
    '{16'h0013, 32'h3333_0003, 1'b1},  // merges into second entry (R2)
    '{16'h0020, 32'h4444_0000, 1'b1},  // new block
    '{16'h0011, 32'h5555_0001, 1'b1},  // overwrite word 1 (R3)
    '{16'h0031, 32'h6666_0001, 1'b1},  // fills the last entry
    '{16'h0042, 32'h7777_0002, 1'b0},  // full, no match: stall (R5)
    '{16'h0022, 32'h8888_0002, 1'b1},  // full, match: accepted (R5)
    '{16'h0012, 32'h9999_0002, 1'b1},  // merge
    '{16'h0010, 32'hAAAA_0000, 1'b1}   // head excluded, merges into second (R4)
  };

  localparam drain_t DRAIN [4] = '{
    '{14'h004, 4'b0001, {32'h0, 32'h0, 32'h0, 32'h1111_0000}},
    '{14'h004, 4'b1111, {32'h3333_0003, 32'h9999_0002, 32'h5555_0001, 32'hAAAA_0000}},
    '{14'h008, 4'b0101, {32'h0, 32'h8888_0002, 32'h0, 32'h4444_0000}},
    '{14'h00C, 4'b0010, {32'h0, 32'h0, 32'h6666_0001, 32'h0}}
  };

  task automatic chk(input bit ok, input string req, input logic [BD_W-1:0] act,
                     input logic [BD_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic exp_rdy, input string req);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    #1;
    chk(st_ready == exp_rdy, req, BD_W'(st_ready), BD_W'(exp_rdy));
    @(posedge clk);
    #1;
    st_valid = 1'b0;
  endtask

  task automatic expect_drain(input logic [BLK_W-1:0] blk, input logic [WORDS-1:0] mask,
                              input logic [BD_W-1:0] data, input string req);
    @(negedge clk);
    #1;
    chk(mw_valid == 1'b1, {req, " drain valid"}, BD_W'(mw_valid), BD_W'(1));
    chk(mw_addr == blk, {req, " drain address"}, BD_W'(mw_addr), BD_W'(blk));
    chk(mw_mask == mask, {req, " drain mask"}, BD_W'(mw_mask), BD_W'(mask));
    for (int k = 0; k < WORDS; k++) begin
      if (mask[k])
        chk(mw_data[k*DATA_W +: DATA_W] == data[k*DATA_W +: DATA_W],
            {req, " drain word"}, BD_W'(mw_data[k*DATA_W +: DATA_W]),
            BD_W'(data[k*DATA_W +: DATA_W]));
    end
    mw_ready = 1'b1;
    @(posedge clk);
    #1;
    mw_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    #1;
    chk(mw_valid == 1'b0, req, BD_W'(mw_valid), BD_W'(0));
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(mw_valid == 1'b0, "R11 valid in reset", BD_W'(mw_valid), BD_W'(0));
    chk(st_ready == 1'b1, "R11 ready in reset", BD_W'(st_ready), BD_W'(1));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mw_valid == 1'b0, "R11 valid after reset", BD_W'(mw_valid), BD_W'(0));
    chk(st_ready == 1'b1, "R11 ready after reset", BD_W'(st_ready), BD_W'(1));

    // R1: single store into empty buffer appears next cycle
    do_store({14'h001, 2'd1}, 32'hC0DE_0001, 1'b1, "R1 empty accept");
    expect_drain(14'h001, 4'b0010, {32'h0, 32'h0, 32'hC0DE_0001, 32'h0}, "R1 R7");
    expect_empty("R1 drained");

    // Table: merge, overwrite, head lock, full stall (memory stalled)
    for (int v = 0; v < 10; v++)
      do_store(STIM[v].addr, STIM[v].data, STIM[v].rdy, "R2 R4 R5 store acceptance");
    for (int v = 0; v < 4; v++)
      expect_drain(DRAIN[v].blk, DRAIN[v].mask, DRAIN[v].data, "R2 R3 R4 R6 R7 R8");
    expect_empty("R5 rejected store left no entry");

    // R9 and R6: freed slot reusable only from the next cycle
    for (int i = 0; i < 4; i++)
      do_store({14'h070 + 14'(i), 2'(i)}, 32'h7000_0000 + i, 1'b1, "R9 fill");
    @(negedge clk);
    mw_ready = 1'b1;
    st_valid = 1'b1;
    st_addr  = {14'h074, 2'd0};
    st_data  = 32'h7000_0004;
    #1;
    chk(st_ready == 1'b0, "R9 ready in drain cycle", BD_W'(st_ready), BD_W'(0));
    chk(mw_addr == 14'h070, "R6 oldest offered", BD_W'(mw_addr), BD_W'(14'h070));
    @(posedge clk);
    #1;
    mw_ready = 1'b0;
    @(negedge clk);
    #1;
    chk(st_ready == 1'b1, "R9 ready after drain", BD_W'(st_ready), BD_W'(1));
    @(posedge clk);
    #1;
    st_valid = 1'b0;
    for (int i = 1; i < 5; i++)
      expect_drain(14'h070 + 14'(i), 4'(1 << (i % 4)),
                   BD_W'(32'h7000_0000 + i) << ((i % 4) * DATA_W), "R6 R9 order");
    expect_empty("R6 all drained");

    // R10: merge and drain in the same cycle
    do_store({14'h050, 2'd0}, 32'hD5D5_0000, 1'b1, "R10 setup");
    do_store({14'h060, 2'd1}, 32'hD6D6_0001, 1'b1, "R10 setup");
    @(negedge clk);
    mw_ready = 1'b1;
    st_valid = 1'b1;
    st_addr  = {14'h060, 2'd2};
    st_data  = 32'hE6E6_0002;
    #1;
    chk(st_ready == 1'b1, "R10 merge accepted", BD_W'(st_ready), BD_W'(1));
    chk(mw_addr == 14'h050, "R10 drain head", BD_W'(mw_addr), BD_W'(14'h050));
    chk(mw_data[DATA_W-1:0] == 32'hD5D5_0000, "R10 drain data",
        BD_W'(mw_data[DATA_W-1:0]), BD_W'(32'hD5D5_0000));
    @(posedge clk);
    #1;
    mw_ready = 1'b0;
    st_valid = 1'b0;
    expect_drain(14'h060, 4'b0110, {32'h0, 32'hE6E6_0002, 32'hD6D6_0001, 32'h0}, "R10");
    expect_empty("R10 drained");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule